// File: doc/BRIEF.md
# Buffered Timer Compare Channel

This block is one compare channel of a timer. Software loads a 16-bit compare value over an 8-bit register bus as two byte writes: the high byte goes into a holding latch, and the low-byte write then moves both bytes into the target register in one clock. The block compares that value with the timer count on every clock. On equality it drives a match pulse to the waveform logic and sets a sticky compare flag, which serves as the interrupt request.

A 4-bit waveform mode code is decoded through parameter tables. Each code is either PWM or non-PWM, and each PWM code has an update point at TOP or at BOTTOM. In PWM codes, the low-byte write fills a shadow buffer. The shadow buffer is copied into the active compare register only when the count reaches that update point, so a pulse width never changes in the middle of a period. In non-PWM codes the buffer is bypassed. The same codes also accept a force strobe, which produces a match pulse without setting the flag.

Top module: `ocu_top`

## Requirements
- R1: A write with `wr_hi`=1 stores `wr_data` only in the holding latch, and `cmp_value` does not change.
- R2: In a non-PWM code (0, 4, 12, 13), a write with `wr_hi`=0 makes `cmp_value` equal {latch, `wr_data`} after the next clock edge.
- R3: In a PWM code (every other code), a write with `wr_hi`=0 loads {latch, `wr_data`} into the shadow buffer and leaves `cmp_value` unchanged.
- R4: For PWM codes other than 8 and 9, the buffer is copied into `cmp_value` on a clock where `at_top`=1, and `at_bottom` has no effect.
- R5: For codes 8 and 9, the copy happens on a clock where `at_bottom`=1, and `at_top` has no effect.
- R6: `rd_data` returns a byte of the target register: the buffer in PWM codes and `cmp_value` otherwise. `rd_hi`=1 selects bits 15:8 and `rd_hi`=0 selects bits 7:0. The holding latch is never read.
- R7: `match_out` is 1 in the same cycle that `cnt` equals `cmp_value`, and `flag` is 1 after that clock edge.
- R8: `flag` stays 1 until a cycle with `flag_clr`=1 and no equality. If a clear and an equality fall in the same cycle, the flag stays set.
- R9: In a non-PWM code, `force_wr`=1 drives `match_out` to 1 in that cycle and does not set `flag`.
- R10: In a PWM code, `force_wr` has no effect on `match_out` or `flag`.
- R11: After reset, `cmp_value`, the buffer and the latch are 0 and `flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 4 | Waveform mode code |
| wr_en | input | 1 | Byte write strobe |
| wr_hi | input | 1 | 1 selects the high-byte address, 0 the low-byte address |
| wr_data | input | 8 | Write byte |
| rd_hi | input | 1 | Read byte select |
| rd_data | output | 8 | Read byte of the target register |
| force_wr | input | 1 | One-cycle force-compare strobe |
| flag_clr | input | 1 | Write-one-to-clear of the flag |
| cnt | input | 16 | Timer count |
| at_top | input | 1 | Count is at TOP this cycle |
| at_bottom | input | 1 | Count is at BOTTOM this cycle |
| cmp_value | output | 16 | Active compare register |
| match_out | output | 1 | Match pulse toward the waveform logic |
| flag | output | 1 | Sticky compare flag (interrupt request) |

## Verification
The assertions assume that the mode code stays constant around a write and that `at_top` and `at_bottom` are single-cycle pulses that the counter drives. They also assume that `flag_clr` and `force_wr` are strobes held for at most one cycle per operation. The stimulus changes all inputs only at falling edges. It changes `mode` only while no write or update pulse is pending, raises each update pulse for exactly one cycle, and parks `cnt` away from the compare value whenever a match is not intended.

// File: rtl/ocu_pkg.sv
// Shared definitions for the compare channel: the mode decode result type
// and the table lookup that classifies a mode code. Assumes the tables are
// 2**MODE_W bits wide, with bit i describing code i.
package ocu_pkg;

    typedef struct packed {
        logic pwm;        // shadow buffer in use
        logic upd_bottom; // commit at BOTTOM rather than TOP
    } mode_cls_t;

    function automatic mode_cls_t classify(input logic [15:0] pwm_tab,
                                           input logic [15:0] bot_tab,
                                           input logic [3:0]  code);
        mode_cls_t r;
        r.pwm        = pwm_tab[code];
        r.upd_bottom = bot_tab[code];
        return r;
    endfunction

endpackage

// File: rtl/ocu_byte_port.sv
// Byte-wide write path. A high-byte write fills the holding latch. A
// low-byte write emits a full word made of the latch and the low byte as a
// one-cycle request. Assumes the host writes the high byte first.
module ocu_byte_port #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic                word_we,
    output logic [2*BYTE_W-1:0] word_data
);
    logic [BYTE_W-1:0] hold_q;

    // Holding latch for the high byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (wr_en && wr_hi)
            hold_q <= wr_data;
    end

    // Word request formed on a low-byte write
    always_comb begin
        word_we   = wr_en && !wr_hi;
        word_data = {hold_q, wr_data};
    end
endmodule

// File: rtl/ocu_cmp_regs.sv
// Shadow buffer and active compare register. A word write goes to the
// buffer in PWM codes and straight to the active register otherwise. The
// buffer is copied to the active register at the selected update point.
// Assumes update pulses come from the counter and last one cycle.
module ocu_cmp_regs #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm,
    input  logic              upd_bottom,
    input  logic              at_top,
    input  logic              at_bottom,
    input  logic              word_we,
    input  logic [WORD_W-1:0] word_data,
    output logic [WORD_W-1:0] shadow,
    output logic [WORD_W-1:0] active
);
    logic commit;

    // Commit condition for buffered modes
    always_comb commit = pwm && (upd_bottom ? at_bottom : at_top);

    // Shadow buffer, written only in PWM codes
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else if (word_we && pwm)
            shadow <= word_data;
    end

    // Active register: direct write or commit from the buffer
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= '0;
        else if (word_we && !pwm)
            active <= word_data;
        else if (commit)
            active <= shadow;
    end
endmodule

// File: rtl/ocu_match.sv
// Equality compare, match pulse and sticky flag. A force strobe is honoured
// only in non-PWM codes and never touches the flag. Assumes flag_clr is a
// one-cycle write-one-to-clear strobe.
module ocu_match #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm,
    input  logic [WORD_W-1:0] cnt,
    input  logic [WORD_W-1:0] active,
    input  logic              force_wr,
    input  logic              flag_clr,
    output logic              match_out,
    output logic              flag
);
    logic eq;

    // Continuous compare and match pulse toward the waveform logic
    always_comb begin
        eq        = (cnt == active);
        match_out = eq || (force_wr && !pwm);
    end

    // Sticky flag: a set beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (eq)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/ocu_top.sv
// Compare channel top. It joins the byte write port, the buffered registers
// and the match logic, decodes the mode code through parameter tables, and
// serves the byte read of the target register. Assumes the mode code is
// steady while a write sequence is in flight.
module ocu_top #(
    parameter int          BYTE_W   = 8,
    parameter int          MODE_W   = 4,
    parameter logic [15:0] PWM_TAB  = 16'hCFEE,
    parameter logic [15:0] BOT_TAB  = 16'h0300
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode,
    input  logic                wr_en,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_hi,
    output logic [BYTE_W-1:0]   rd_data,
    input  logic                force_wr,
    input  logic                flag_clr,
    input  logic [2*BYTE_W-1:0] cnt,
    input  logic                at_top,
    input  logic                at_bottom,
    output logic [2*BYTE_W-1:0] cmp_value,
    output logic                match_out,
    output logic                flag
);
    import ocu_pkg::*;

    localparam int WORD_W = 2 * BYTE_W;

    mode_cls_t          cls;
    logic               word_we;
    logic [WORD_W-1:0]  word_data;
    logic [WORD_W-1:0]  shadow;
    logic [WORD_W-1:0]  target;

    // Mode classification from the parameter tables
    always_comb cls = classify(PWM_TAB, BOT_TAB, 4'(mode));

    ocu_byte_port #(.BYTE_W(BYTE_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_hi     (wr_hi),
        .wr_data   (wr_data),
        .word_we   (word_we),
        .word_data (word_data)
    );

    ocu_cmp_regs #(.WORD_W(WORD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm        (cls.pwm),
        .upd_bottom (cls.upd_bottom),
        .at_top     (at_top),
        .at_bottom  (at_bottom),
        .word_we    (word_we),
        .word_data  (word_data),
        .shadow     (shadow),
        .active     (cmp_value)
    );

    ocu_match #(.WORD_W(WORD_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm       (cls.pwm),
        .cnt       (cnt),
        .active    (cmp_value),
        .force_wr  (force_wr),
        .flag_clr  (flag_clr),
        .match_out (match_out),
        .flag      (flag)
    );

    // Read path: target register byte, never the holding latch
    always_comb begin
        target  = cls.pwm ? shadow : cmp_value;
        rd_data = rd_hi ? target[WORD_W-1:BYTE_W] : target[BYTE_W-1:0];
    end
endmodule

// File: rtl/ocu_checker.sv
// Protocol checker for ocu_top, attached by bind. Assumes update pulses
// and strobes as described in the brief.
module ocu_checker #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_hi,
    input logic              at_top,
    input logic              at_bottom,
    input logic              flag_clr,
    input logic [WORD_W-1:0] cnt,
    input logic [WORD_W-1:0] cmp_value,
    input logic              match_out,
    input logic              flag
);
    // R1: without a low-byte write or an update pulse the active value holds
    a_r1_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && !wr_hi) && !at_top && !at_bottom) |=> $stable(cmp_value));

    // R7: equality sets the flag on the next edge
    a_r7_eq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == cmp_value) |=> flag);

    // R7: equality always shows on the match output
    a_r7_eq_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == cmp_value) |-> match_out);

    // R8: the flag holds without a clear
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R9: the flag rises only after an equality, never from a force
    a_r9_flag_needs_eq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(cnt == cmp_value));
endmodule

bind ocu_top ocu_checker #(.WORD_W(2 * BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_hi     (wr_hi),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .flag_clr  (flag_clr),
    .cnt       (cnt),
    .cmp_value (cmp_value),
    .match_out (match_out),
    .flag      (flag)
);

// File: tb/sim_ocu_top.sv
module sim_ocu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_hi = 1'b0;
    logic [7:0]  rd_data;
    logic        force_wr = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] cnt = 16'hFFFF;
    logic        at_top = 1'b0;
    logic        at_bottom = 1'b0;
    logic [15:0] cmp_value;
    logic        match_out;
    logic        flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ocu_top u0 (.*);

    // Vector: mode, high byte, low byte, count
    localparam logic [35:0] VEC [6] = '{
        {4'd0,  8'h12, 8'h34, 16'h1234},
        {4'd4,  8'hAB, 8'hCD, 16'hABCC},
        {4'd12, 8'h00, 8'h01, 16'h0001},
        {4'd0,  8'hFF, 8'hFF, 16'hFFFE},
        {4'd13, 8'h80, 8'h00, 16'h8000},
        {4'd4,  8'h5A, 8'hA5, 16'h5AA5}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic hi, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_top();
        @(negedge clk); at_top = 1'b1;
        @(negedge clk); at_top = 1'b0;
    endtask

    task automatic pulse_bot();
        @(negedge clk); at_bottom = 1'b1;
        @(negedge clk); at_bottom = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 cmp", cmp_value, 16'h0000);
        check("R11 flag", {15'd0, flag}, 16'd0);
        rd_hi = 1'b1; #1;
        check("R11 rd", {8'd0, rd_data}, 16'd0);

        // Table walk over non-PWM codes: R2, R6, R7
        for (int i = 0; i < 6; i++) begin
            logic [15:0] w;
            logic [15:0] c;
            w = VEC[i][31:16];
            c = VEC[i][15:0];
            @(negedge clk); mode = VEC[i][35:32]; cnt = 16'hFFFF;
            if (w == 16'hFFFF) cnt = 16'h0000;
            wr(1'b1, w[15:8]);
            wr(1'b0, w[7:0]);
            check("R2 direct write", cmp_value, w);
            rd_hi = 1'b0; #1;
            check("R6 read low", {8'd0, rd_data}, {8'd0, w[7:0]});
            cnt = c; #1;
            check("R7 match pulse", {15'd0, match_out}, {15'd0, c == w});
            @(negedge clk);
            check("R7 flag", {15'd0, flag}, {15'd0, c == w});
            cnt = w + 16'd7;
            clear_flag();
        end

        // R1: a high-byte write alone leaves the compare value
        @(negedge clk); mode = 4'd0; cnt = 16'h0F0F;
        wr(1'b1, 8'hEE);
        check("R1 hi only", cmp_value, 16'h5AA5);

        // R8: flag sticky, clear loses to a simultaneous match
        @(negedge clk); cnt = 16'h5AA5;
        @(negedge clk); cnt = 16'h0F0F;
        @(negedge clk);
        check("R8 sticky", {15'd0, flag}, 16'd1);
        cnt = 16'h5AA5; flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0; cnt = 16'h0F0F;
        check("R8 set wins", {15'd0, flag}, 16'd1);
        clear_flag();
        check("R8 cleared", {15'd0, flag}, 16'd0);

        // R9: force in a non-PWM code
        @(negedge clk); force_wr = 1'b1; #1;
        check("R9 force pulse", {15'd0, match_out}, 16'd1);
        @(negedge clk); force_wr = 1'b0;
        check("R9 no flag", {15'd0, flag}, 16'd0);

        // R3/R4: TOP-update PWM code 14
        @(negedge clk); mode = 4'd14;
        wr(1'b1, 8'h12);
        wr(1'b0, 8'h34);
        check("R3 buffered", cmp_value, 16'h5AA5);
        rd_hi = 1'b1; #1;
        check("R6 read buffer", {8'd0, rd_data}, 16'h0012);
        pulse_bot();
        check("R4 bottom ignored", cmp_value, 16'h5AA5);
        pulse_top();
        check("R4 top commit", cmp_value, 16'h1234);

        // R10: force ignored in PWM
        @(negedge clk); force_wr = 1'b1; #1;
        check("R10 force ignored", {15'd0, match_out}, 16'd0);
        @(negedge clk); force_wr = 1'b0;
        check("R10 no flag", {15'd0, flag}, 16'd0);

        // R5: BOTTOM-update code 8
        @(negedge clk); mode = 4'd8;
        wr(1'b1, 8'h56);
        wr(1'b0, 8'h78);
        pulse_top();
        check("R5 top ignored", cmp_value, 16'h1234);
        pulse_bot();
        check("R5 bottom commit", cmp_value, 16'h5678);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end
endmodule